// File: doc/BRIEF.md
# Priority Level Interrupt Arbiter

This block picks one winner among the maskable interrupt groups of a processor's interrupt controller and tells the processor the level of that winner. Groups are numbered 2 to 30. Each group supplies three things from the group register block: a 4-bit request vector, a 4-bit enable vector and a 3-bit level. Level 0 is the most urgent and level 7 is the least urgent. The arbiter reduces these inputs to one registered level output.

When the processor takes an interrupt, it acknowledges with the level it saw. If that level matches, the arbiter records the winning group number. Software can later read that number back through a byte-wide read port. The read returns zero if the recorded group has meanwhile lost every enabled request.

An acknowledge whose level does not match the current output is not recorded. Instead it raises a sticky error flag.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A group is pending only when at least one bit is set in both its request vector and its enable vector. A request bit whose enable bit is clear has no effect on the level output.
- R2: Among pending groups, the one with the numerically smallest level wins. A group must be strictly lower in level to displace another.
- R3: When pending groups share the smallest level, the lowest group number wins.
- R4: With no group pending, the winner is group 0 and the level output is 7. A pending group whose level is 7 never displaces group 0.
- R5: `lvl_o` is registered. It reflects any change of request, enable or level inputs on the clock edge that follows the change.
- R6: An acknowledge whose level equals the current `lvl_o` stores the current winner's group number as the accepted group.
- R7: A read of address 0 returns, one cycle after `rd_en_i`, the accepted group number shifted left by two. It returns 0 if that group currently has no request bit that is also enabled. Group 0 always reads as 0.
- R8: An acknowledge whose level differs from `lvl_o` leaves the accepted group unchanged and sets `ack_err_o`. The flag stays set until reset.
- R9: A read of address 1 returns 0.
- R10: After a synchronous reset, the accepted group is 0, `lvl_o` is 7 and `ack_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_req_i | input | 116 | Request vectors, 4 bits per group; bits [4k+3:4k] belong to group k+2 |
| grp_en_i | input | 116 | Enable vectors, same layout as requests |
| grp_lvl_i | input | 87 | Levels, 3 bits per group; bits [3k+2:3k] belong to group k+2 |
| lvl_o | output | 3 | Registered level of the current winner (7 when idle) |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_lvl_i | input | 3 | Level carried by the acknowledge |
| ack_err_o | output | 1 | Sticky flag: an acknowledge carried a mismatched level |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 1 | Byte select: 0 = group byte, 1 = upper byte |
| rd_data_o | output | 8 | Registered read data |

## Verification
An error in the pending mask or in the priority scan shows at `lvl_o` one clock after the stimulus. Such errors also show when the stored group is read back with an acknowledge and a read, three cycles later. A wrong accepted-group register can stay hidden until a read. For that reason each acknowledge scenario is followed by a read of address 0.

Some errors are visible only through the live-pending gating of the readback. These include reading a stale group after its request drops, and latching a group that loses to the idle level 7. Both show up as a nonzero byte where 0 is expected.

// File: rtl/prio_irq_arbiter_pkg.sv
package prio_irq_arbiter_pkg;
  localparam int unsigned ARB_FIRST_GRP = 2;
  localparam int unsigned ARB_LAST_GRP  = 30;
  localparam int unsigned ARB_SRC_W     = 4;
  localparam int unsigned ARB_LVL_W     = 3;
  localparam int unsigned ARB_IDLE_LVL  = 7;
  localparam int unsigned ARB_DATA_W    = 8;
endpackage

// File: rtl/irq_pend_gate.sv
module irq_pend_gate #(
  parameter int unsigned NUM_GRP = 29,
  parameter int unsigned SRC_W   = 4
) (
  input  logic [NUM_GRP*SRC_W-1:0] req_i,
  input  logic [NUM_GRP*SRC_W-1:0] en_i,
  output logic [NUM_GRP-1:0]       pend_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign pend_o[g] = |(req_i[g*SRC_W +: SRC_W] & en_i[g*SRC_W +: SRC_W]);
  end
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int unsigned NUM_GRP  = 29,
  parameter int unsigned FIRST    = 2,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned GRP_W    = 5,
  parameter int unsigned IDLE_LVL = 7
) (
  input  logic [NUM_GRP-1:0]       pend_i,
  input  logic [NUM_GRP*LVL_W-1:0] lvl_i,
  output logic [GRP_W-1:0]         win_grp_o,
  output logic [LVL_W-1:0]         win_lvl_o
);
  logic [GRP_W-1:0] sel_g;
  logic [LVL_W-1:0] sel_l;

  // Ascending scan with strict compare: ties keep the lower group.
  always_comb begin
    sel_g = '0;
    sel_l = LVL_W'(IDLE_LVL);
    for (int g = 0; g < NUM_GRP; g++) begin
      if (pend_i[g] && (lvl_i[g*LVL_W +: LVL_W] < sel_l)) begin
        sel_l = lvl_i[g*LVL_W +: LVL_W];
        sel_g = GRP_W'(g + FIRST);
      end
    end
  end

  assign win_grp_o = sel_g;
  assign win_lvl_o = sel_l;
endmodule

// File: rtl/irq_accept_reg.sv
module irq_accept_reg #(
  parameter int unsigned NUM_GRP = 29,
  parameter int unsigned FIRST   = 2,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned GRP_W   = 5,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  input  logic [LVL_W-1:0]   cur_lvl_i,
  input  logic [GRP_W-1:0]   cur_grp_i,
  input  logic [NUM_GRP-1:0] pend_i,
  input  logic               rd_en_i,
  input  logic               rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               ack_err_o
);
  localparam int unsigned LAST = FIRST + NUM_GRP - 1;

  logic [GRP_W-1:0]  acc_q;
  logic              acc_live;
  logic [GRP_W-1:0]  acc_idx;
  logic [DATA_W-1:0] byte0;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      ack_err_o <= 1'b0;
    end else if (ack_i) begin
      if (ack_lvl_i == cur_lvl_i) acc_q <= cur_grp_i;
      else                        ack_err_o <= 1'b1;
    end
  end

  assign acc_idx = acc_q - GRP_W'(FIRST);

  always_comb begin
    acc_live = 1'b0;
    if ((32'(acc_q) >= FIRST) && (32'(acc_q) <= LAST))
      acc_live = pend_i[acc_idx];
  end

  assign byte0 = acc_live ? (DATA_W'(acc_q) << 2) : '0;

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_addr_i ? '0 : byte0;
  end

  // R6
  ack_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && ack_lvl_i == cur_lvl_i) |=> acc_q == $past(cur_grp_i));
  // R8
  ack_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && ack_lvl_i != cur_lvl_i) |=> (ack_err_o && acc_q == $past(acc_q)));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ack_err_o |=> ack_err_o);
  // R9
  upper_byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i) |=> rd_data_o == '0);
  // R7
  byte0_align_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !rd_addr_i) |=> rd_data_o[1:0] == 2'b00);
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_irq_arbiter_pkg::*;
#(
  parameter int unsigned FIRST_GRP = ARB_FIRST_GRP,
  parameter int unsigned LAST_GRP  = ARB_LAST_GRP,
  parameter int unsigned SRC_W     = ARB_SRC_W,
  parameter int unsigned LVL_W     = ARB_LVL_W,
  parameter int unsigned IDLE_LVL  = ARB_IDLE_LVL,
  parameter int unsigned DATA_W    = ARB_DATA_W,
  localparam int unsigned NUM_GRP  = LAST_GRP - FIRST_GRP + 1,
  localparam int unsigned GRP_W    = $clog2(LAST_GRP + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_GRP*SRC_W-1:0]   grp_req_i,
  input  logic [NUM_GRP*SRC_W-1:0]   grp_en_i,
  input  logic [NUM_GRP*LVL_W-1:0]   grp_lvl_i,
  output logic [LVL_W-1:0]           lvl_o,
  input  logic                       ack_i,
  input  logic [LVL_W-1:0]           ack_lvl_i,
  output logic                       ack_err_o,
  input  logic                       rd_en_i,
  input  logic                       rd_addr_i,
  output logic [DATA_W-1:0]          rd_data_o
);
  logic [NUM_GRP-1:0] pend_w;
  logic [GRP_W-1:0]   win_grp_w, grp_q;
  logic [LVL_W-1:0]   win_lvl_w;

  irq_pend_gate #(.NUM_GRP(NUM_GRP), .SRC_W(SRC_W)) u_gate (
    .req_i(grp_req_i), .en_i(grp_en_i), .pend_o(pend_w));

  irq_prio_scan #(.NUM_GRP(NUM_GRP), .FIRST(FIRST_GRP), .LVL_W(LVL_W),
                  .GRP_W(GRP_W), .IDLE_LVL(IDLE_LVL)) u_scan (
    .pend_i(pend_w), .lvl_i(grp_lvl_i),
    .win_grp_o(win_grp_w), .win_lvl_o(win_lvl_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o <= LVL_W'(IDLE_LVL);
      grp_q <= '0;
    end else begin
      lvl_o <= win_lvl_w;
      grp_q <= win_grp_w;
    end
  end

  irq_accept_reg #(.NUM_GRP(NUM_GRP), .FIRST(FIRST_GRP), .LVL_W(LVL_W),
                   .GRP_W(GRP_W), .DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .ack_i(ack_i), .ack_lvl_i(ack_lvl_i),
    .cur_lvl_i(lvl_o), .cur_grp_i(grp_q), .pend_i(pend_w),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .ack_err_o(ack_err_o));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_w == '0) |=> lvl_o == LVL_W'(IDLE_LVL));
  // R4
  idle_group_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_o == LVL_W'(IDLE_LVL)) |-> grp_q == '0);
  // R5
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(grp_lvl_i) && $stable(pend_w) |=> $stable(lvl_o));
endmodule

// File: tb/prio_irq_arbiter_tb.sv
module prio_irq_arbiter_tb;
  localparam int NG = 29;
  logic clk = 1'b0;
  logic rst;
  logic [NG*4-1:0] req, en;
  logic [NG*3-1:0] lvl;
  logic [2:0] lvl_o, ack_lvl;
  logic ack, ack_err, rd_en, rd_addr;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_arbiter u_dut (
    .clk(clk), .rst(rst), .grp_req_i(req), .grp_en_i(en), .grp_lvl_i(lvl),
    .lvl_o(lvl_o), .ack_i(ack), .ack_lvl_i(ack_lvl), .ack_err_o(ack_err),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_grp(int g, logic [3:0] r, logic [3:0] e, logic [2:0] l);
    req[(g-2)*4 +: 4] = r;
    en[(g-2)*4 +: 4]  = e;
    lvl[(g-2)*3 +: 3] = l;
  endtask

  task automatic clear_all();
    req = '0; en = '0; lvl = '1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_ack(logic [2:0] l);
    ack = 1'b1; ack_lvl = l; step(); ack = 1'b0;
  endtask

  task automatic do_read(logic a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a; step(); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 level after reset", lvl_o, 7);
    chk("R10 err after reset", ack_err, 0);
    do_read(1'b0, d);
    chk("R10 accepted after reset", d, 0);
  endtask

  task automatic t_mask();
    clear_all(); set_grp(5, 4'b0010, 4'b0010, 3'd3); step();
    chk("R1 enabled request level", lvl_o, 3);
    set_grp(5, 4'b0010, 4'b0001, 3'd3); step();
    chk("R1 masked request ignored", lvl_o, 7);
  endtask

  task automatic t_tie();
    logic [7:0] d;
    clear_all();
    set_grp(20, 4'b1000, 4'b1000, 3'd2);
    set_grp(9, 4'b0001, 4'b0011, 3'd2); step();
    chk("R3 tie level", lvl_o, 2);
    do_ack(3'd2); do_read(1'b0, d);
    chk("R3 tie lower group wins", d, 9 << 2);
  endtask

  task automatic t_lower();
    logic [7:0] d;
    lvl[(20-2)*3 +: 3] = 3'd1; step();
    chk("R5 R2 level change followed", lvl_o, 1);
    do_ack(3'd1); do_read(1'b0, d);
    chk("R2 R6 lower level wins", d, 20 << 2);
  endtask

  task automatic t_idle7();
    logic [7:0] d;
    clear_all(); set_grp(12, 4'b0100, 4'b0100, 3'd7); step();
    chk("R4 level-7 group stays idle", lvl_o, 7);
    do_ack(3'd7); do_read(1'b0, d);
    chk("R4 R7 group 0 accepted reads 0", d, 0);
    chk("R6 matched ack no error", ack_err, 0);
  endtask

  task automatic t_drop();
    logic [7:0] d;
    clear_all(); set_grp(30, 4'b0001, 4'b0001, 3'd0); step();
    chk("R2 level 0", lvl_o, 0);
    do_ack(3'd0); do_read(1'b0, d);
    chk("R7 group 30 readback", d, 120);
    do_read(1'b1, d);
    chk("R9 upper byte zero", d, 0);
    set_grp(30, 4'b0000, 4'b0001, 3'd0); do_read(1'b0, d);
    chk("R7 dropped request reads 0", d, 0);
    chk("R5 level back to idle", lvl_o, 7);
    set_grp(30, 4'b0001, 4'b0001, 3'd0); do_read(1'b0, d);
    chk("R7 accepted group retained", d, 120);
  endtask

  task automatic t_mismatch();
    logic [7:0] d;
    clear_all(); set_grp(3, 4'b0001, 4'b0001, 3'd4);
    set_grp(30, 4'b0001, 4'b0001, 3'd5); step();
    chk("R2 level 4", lvl_o, 4);
    do_ack(3'd6);
    chk("R8 mismatch sets error", ack_err, 1);
    do_read(1'b0, d);
    chk("R8 accepted unchanged", d, 120);
    repeat (3) step();
    chk("R8 error sticky", ack_err, 1);
    do_ack(3'd4);
    chk("R8 error stays after good ack", ack_err, 1);
    do_read(1'b0, d);
    chk("R6 good ack after error latches", d, 3 << 2);
  endtask

  initial begin
    rst = 1'b1; ack = 0; ack_lvl = 0; rd_en = 0; rd_addr = 0;
    clear_all();
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_mask();
    t_tie();
    t_lower();
    t_idle7();
    t_drop();
    t_mismatch();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule